// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block turns host I/O cycles on a two-port configuration mechanism into configuration requests for the function register files on one bus. The host first stores a 32-bit selector in the address port. The selector holds an enable flag, a bus number, a device/function number and a register offset. Later accesses to the 4-byte data window become reads or writes of the selected register. The address port sits at I/O 0xCF8. The data window covers 0xCFC to 0xCFF, and its byte offset arrives on `host_byte_off`.

The bridge forwards a data access only when three conditions hold: the enable flag is set, the bus field equals the bridge's own bus number, and the selected device/function is marked present in `dev_present`. In every other case it finishes the access locally. A read then returns all-ones sized to the access, and a write is dropped. A forwarded request is held until the target raises `cfg_req_ready`. The target places read data on `cfg_rdata` in the cycle after that handshake.

Every host access gets exactly one `host_done` pulse. The host starts a new access only after that pulse. Any `host_valid` seen while an access is still open is ignored.

Top module: `cfg_port_bridge`

## Requirements
- R1: A dword write (`host_size` = 2'b10) to the address port (`host_port` = 0) loads the selector latch. A dword read of the address port returns the latch value. Both raise `host_done` in the first cycle after acceptance.
- R2: A byte (2'b00) or word (2'b01) access to the address port leaves the latch unchanged. A narrow read returns 0xFF or 0xFFFF.
- R3: When latch bit 31 is clear, a data-port (`host_port` = 1) read returns 0xFF, 0xFFFF or 0xFFFFFFFF for byte, word or dword. A data-port write issues no request. Either access completes one cycle after acceptance.
- R4: When latch bits [23:16] differ from `BRIDGE_BUS`, or `dev_present` has a zero at index latch[15:8], data-port accesses behave exactly as in R3.
- R5: A forwarded request carries devfn = latch[15:8]. For dword accesses the register offset is latch[7:0] with bits [1:0] forced to zero. For byte and word accesses it is latch[7:0] OR `host_byte_off`.
- R6: Write data on the request is `host_wdata` with the bytes above the access size zeroed; narrow data sits in the low bits. Read data returned to the host is `cfg_rdata` masked to the access size.
- R7: The request stays asserted with stable fields until `cfg_req_ready`. `host_done` rises two cycles after the handshake edge, so a read with S stall cycles completes 3+S cycles after acceptance.
- R8: After reset the latch is zero, and no request and no done pulse are pending.
- R9: A `host_valid` arriving while a forwarded access is open is ignored and does not alter the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access strobe, one cycle |
| host_port | input | 1 | 0 = address port, 1 = data window |
| host_byte_off | input | 2 | Byte offset inside the data window |
| host_size | input | 2 | 00 byte, 01 word, 10 dword (11 acts as dword) |
| host_write | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 32 | Host write data, low-aligned |
| host_done | output | 1 | Access complete pulse |
| host_rdata | output | 32 | Read result, valid with host_done |
| dev_present | input | 256 | One bit per device/function present on the bus |
| cfg_req_valid | output | 1 | Configuration request pending |
| cfg_req_ready | input | 1 | Target accepts the request |
| cfg_req_write | output | 1 | Request is a write |
| cfg_req_devfn | output | 8 | Target device/function |
| cfg_req_reg | output | 8 | Register offset |
| cfg_req_size | output | 2 | Access size, host encoding |
| cfg_req_wdata | output | 32 | Size-masked write data |
| cfg_rdata | input | 32 | Target read data, the cycle after handshake |

## Verification
The case that needs care is a new host strobe arriving while a forwarded request is still stalled by the target. The new strobe could start a second access or rewrite the selector under the open one. The bench holds `cfg_req_ready` low for several cycles and fires an address-port write into that window. It then judges the result in three ways: one handshake only, completion latency still 3+S, and the latch reading back unchanged.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int CFG_DW     = 32;
    localparam int BUS_W      = 8;
    localparam int FN_W       = 8;
    localparam int REG_W      = 8;
    localparam int NUM_FN     = 1 << FN_W;
    localparam int SEL_EN_BIT = 31;
    localparam int SEL_BUS_LO = 16;
    localparam int SEL_FN_LO  = 8;
    localparam int SEL_REG_LO = 0;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_RSVD  = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_REQ  = 2'b01,
        ST_WAIT = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic              write;
        acc_size_e         size;
        logic [FN_W-1:0]   devfn;
        logic [REG_W-1:0]  regoff;
        logic [CFG_DW-1:0] wdata;
    } cfg_req_t;

    function automatic logic is_full(acc_size_e sz);
        return (sz == SZ_DWORD) || (sz == SZ_RSVD);
    endfunction

    function automatic logic [CFG_DW-1:0] size_mask(acc_size_e sz);
        logic [CFG_DW-1:0] m;
        case (sz)
            SZ_BYTE: m = {{(CFG_DW-8){1'b0}}, 8'hFF};
            SZ_WORD: m = {{(CFG_DW-16){1'b0}}, 16'hFFFF};
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfgp_sel_latch.sv
module cfgp_sel_latch
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CFG_DW-1:0] load_data,
    output logic [CFG_DW-1:0] sel_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (load) begin
            sel_q <= load_data;
        end
    end

endmodule

// File: rtl/cfgp_target_decode.sv
module cfgp_target_decode
    import cfgp_pkg::*;
#(
    parameter logic [BUS_W-1:0] BRIDGE_BUS = '0
) (
    input  logic              sel_en,
    input  logic [BUS_W-1:0]  sel_bus,
    input  logic [FN_W-1:0]   sel_fn,
    input  logic [REG_W-1:0]  sel_reg,
    input  logic [1:0]        byte_off,
    input  acc_size_e         size,
    input  logic [NUM_FN-1:0] dev_present,
    output logic              hit,
    output logic [FN_W-1:0]   tgt_fn,
    output logic [REG_W-1:0]  tgt_reg
);

    logic bus_match;
    logic fn_there;

    always_comb begin
        bus_match = (sel_bus == BRIDGE_BUS);
        fn_there  = dev_present[sel_fn];
        hit       = sel_en && bus_match && fn_there;
        tgt_fn    = sel_fn;
        if (is_full(size)) begin
            tgt_reg = {sel_reg[REG_W-1:2], 2'b00};
        end else begin
            tgt_reg = sel_reg | {{(REG_W-2){1'b0}}, byte_off};
        end
    end

endmodule

// File: rtl/cfgp_access_seq.sv
module cfgp_access_seq
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_data_port,
    input  logic              acc_write,
    input  acc_size_e         acc_size,
    input  logic [CFG_DW-1:0] acc_wdata,
    input  logic [CFG_DW-1:0] sel_q,
    input  logic              hit,
    input  logic [FN_W-1:0]   tgt_fn,
    input  logic [REG_W-1:0]  tgt_reg,
    input  logic              req_ready,
    input  logic [CFG_DW-1:0] tgt_rdata,
    output logic              idle,
    output cfg_req_t          req,
    output logic              req_valid,
    output logic              done,
    output logic [CFG_DW-1:0] rdata
);

    seq_state_e        state_q;
    cfg_req_t          req_q;
    logic              done_q;
    logic [CFG_DW-1:0] rdata_q;
    logic [CFG_DW-1:0] local_rd;

    always_comb begin
        if (acc_write) begin
            local_rd = '0;
        end else if (!acc_data_port && is_full(acc_size)) begin
            local_rd = sel_q;
        end else begin
            local_rd = size_mask(acc_size);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (acc_valid) begin
                        if (acc_data_port && hit) begin
                            req_q.write  <= acc_write;
                            req_q.size   <= acc_size;
                            req_q.devfn  <= tgt_fn;
                            req_q.regoff <= tgt_reg;
                            req_q.wdata  <= acc_wdata & size_mask(acc_size);
                            state_q      <= ST_REQ;
                        end else begin
                            done_q  <= 1'b1;
                            rdata_q <= local_rd;
                        end
                    end
                end
                ST_REQ: begin
                    if (req_ready) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    done_q  <= 1'b1;
                    rdata_q <= req_q.write ? '0 : (tgt_rdata & size_mask(req_q.size));
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign idle      = (state_q == ST_IDLE);
    assign req       = req_q;
    assign req_valid = (state_q == ST_REQ);
    assign done      = done_q;
    assign rdata     = rdata_q;

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
    import cfgp_pkg::*;
#(
    parameter logic [BUS_W-1:0] BRIDGE_BUS = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_valid,
    input  logic              host_port,
    input  logic [1:0]        host_byte_off,
    input  logic [1:0]        host_size,
    input  logic              host_write,
    input  logic [CFG_DW-1:0] host_wdata,
    output logic              host_done,
    output logic [CFG_DW-1:0] host_rdata,
    input  logic [NUM_FN-1:0] dev_present,
    output logic              cfg_req_valid,
    input  logic              cfg_req_ready,
    output logic              cfg_req_write,
    output logic [FN_W-1:0]   cfg_req_devfn,
    output logic [REG_W-1:0]  cfg_req_reg,
    output logic [1:0]        cfg_req_size,
    output logic [CFG_DW-1:0] cfg_req_wdata,
    input  logic [CFG_DW-1:0] cfg_rdata
);

    acc_size_e         size_e;
    logic [CFG_DW-1:0] latch_q;
    logic              latch_load;
    logic              seq_idle;
    logic              tgt_hit;
    logic [FN_W-1:0]   tgt_fn;
    logic [REG_W-1:0]  tgt_reg;
    cfg_req_t          req;

    assign size_e     = acc_size_e'(host_size);
    assign latch_load = host_valid && seq_idle && !host_port && host_write && is_full(size_e);

    cfgp_sel_latch i_latch (
        .clk       (clk),
        .rst       (rst),
        .load      (latch_load),
        .load_data (host_wdata),
        .sel_q     (latch_q)
    );

    cfgp_target_decode #(.BRIDGE_BUS(BRIDGE_BUS)) i_decode (
        .sel_en      (latch_q[SEL_EN_BIT]),
        .sel_bus     (latch_q[SEL_BUS_LO +: BUS_W]),
        .sel_fn      (latch_q[SEL_FN_LO +: FN_W]),
        .sel_reg     (latch_q[SEL_REG_LO +: REG_W]),
        .byte_off    (host_byte_off),
        .size        (size_e),
        .dev_present (dev_present),
        .hit         (tgt_hit),
        .tgt_fn      (tgt_fn),
        .tgt_reg     (tgt_reg)
    );

    cfgp_access_seq i_seq (
        .clk           (clk),
        .rst           (rst),
        .acc_valid     (host_valid),
        .acc_data_port (host_port),
        .acc_write     (host_write),
        .acc_size      (size_e),
        .acc_wdata     (host_wdata),
        .sel_q         (latch_q),
        .hit           (tgt_hit),
        .tgt_fn        (tgt_fn),
        .tgt_reg       (tgt_reg),
        .req_ready     (cfg_req_ready),
        .tgt_rdata     (cfg_rdata),
        .idle          (seq_idle),
        .req           (req),
        .req_valid     (cfg_req_valid),
        .done          (host_done),
        .rdata         (host_rdata)
    );

    assign cfg_req_write = req.write;
    assign cfg_req_devfn = req.devfn;
    assign cfg_req_reg   = req.regoff;
    assign cfg_req_size  = req.size;
    assign cfg_req_wdata = req.wdata;

endmodule

// File: rtl/cfg_port_bridge_chk.sv
module cfg_port_bridge_chk
    import cfgp_pkg::*;
#(
    parameter logic [BUS_W-1:0] BRIDGE_BUS = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              host_valid,
    input logic              host_port,
    input logic [1:0]        host_size,
    input logic              host_done,
    input logic [NUM_FN-1:0] dev_present,
    input logic              cfg_req_valid,
    input logic              cfg_req_ready,
    input logic [FN_W-1:0]   cfg_req_devfn,
    input logic [REG_W-1:0]  cfg_req_reg,
    input logic [1:0]        cfg_req_size,
    input logic [CFG_DW-1:0] cfg_req_wdata,
    input logic [CFG_DW-1:0] latch_q
);

    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        cfg_req_valid |-> latch_q[SEL_EN_BIT]); // R3

    AST_REQ_NEEDS_TARGET: assert property (@(posedge clk) disable iff (rst)
        cfg_req_valid |-> (latch_q[SEL_BUS_LO +: BUS_W] == BRIDGE_BUS) && dev_present[cfg_req_devfn]); // R4

    AST_DEVFN_FROM_SEL: assert property (@(posedge clk) disable iff (rst)
        cfg_req_valid |-> cfg_req_devfn == latch_q[SEL_FN_LO +: FN_W]); // R5

    AST_DWORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        cfg_req_valid && cfg_req_size[1] |-> cfg_req_reg[1:0] == 2'b00); // R5

    AST_BYTE_WDATA_CLEAN: assert property (@(posedge clk) disable iff (rst)
        cfg_req_valid && cfg_req_size == 2'b00 |-> cfg_req_wdata[CFG_DW-1:8] == '0); // R6

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        cfg_req_valid && !cfg_req_ready |=> cfg_req_valid && $stable(cfg_req_reg)
            && $stable(cfg_req_devfn) && $stable(cfg_req_wdata)); // R7

    AST_DONE_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
        cfg_req_valid && cfg_req_ready |=> !cfg_req_valid ##1 host_done); // R7

    AST_NARROW_ADDR_KEEPS: assert property (@(posedge clk) disable iff (rst)
        host_valid && !host_port && !host_size[1] |=> $stable(latch_q)); // R2

    AST_BUSY_KEEPS_LATCH: assert property (@(posedge clk) disable iff (rst)
        cfg_req_valid |=> $stable(latch_q)); // R9

endmodule

bind cfg_port_bridge cfg_port_bridge_chk #(.BRIDGE_BUS(BRIDGE_BUS)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .host_valid    (host_valid),
    .host_port     (host_port),
    .host_size     (host_size),
    .host_done     (host_done),
    .dev_present   (dev_present),
    .cfg_req_valid (cfg_req_valid),
    .cfg_req_ready (cfg_req_ready),
    .cfg_req_devfn (cfg_req_devfn),
    .cfg_req_reg   (cfg_req_reg),
    .cfg_req_size  (cfg_req_size),
    .cfg_req_wdata (cfg_req_wdata),
    .latch_q       (latch_q)
);

// File: tb/test_cfg_port_bridge.sv
module test_cfg_port_bridge;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         host_valid = 1'b0;
    logic         host_port = 1'b0;
    logic [1:0]   host_byte_off = 2'b00;
    logic [1:0]   host_size = 2'b10;
    logic         host_write = 1'b0;
    logic [31:0]  host_wdata = '0;
    logic         host_done;
    logic [31:0]  host_rdata;
    logic [255:0] dev_present = '0;
    logic         cfg_req_valid;
    logic         cfg_req_ready = 1'b0;
    logic         cfg_req_write;
    logic [7:0]   cfg_req_devfn;
    logic [7:0]   cfg_req_reg;
    logic [1:0]   cfg_req_size;
    logic [31:0]  cfg_req_wdata;
    logic [31:0]  cfg_rdata = '0;

    int checks = 0;
    int errors = 0;
    int stall_cycles = 0;
    int seen_cnt = 0;
    int hs_count = 0;
    int hold_err = 0;
    logic [7:0]  last_fn, last_reg, watch_reg;
    logic [31:0] last_wdata, watch_wdata;
    logic        last_write;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_port_bridge i_cfg_port_bridge (
        .clk(clk), .rst(rst), .host_valid(host_valid), .host_port(host_port),
        .host_byte_off(host_byte_off), .host_size(host_size), .host_write(host_write),
        .host_wdata(host_wdata), .host_done(host_done), .host_rdata(host_rdata),
        .dev_present(dev_present), .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
        .cfg_req_write(cfg_req_write), .cfg_req_devfn(cfg_req_devfn), .cfg_req_reg(cfg_req_reg),
        .cfg_req_size(cfg_req_size), .cfg_req_wdata(cfg_req_wdata), .cfg_rdata(cfg_rdata)
    );

    function automatic logic [31:0] tgt_val(logic [7:0] fn, logic [7:0] rg);
        return {fn ^ 8'h5A, rg, ~rg, fn};
    endfunction

    // Target model: response data the cycle after the handshake
    always @(posedge clk) begin
        if (cfg_req_valid && cfg_req_ready) begin
            cfg_rdata  <= cfg_req_write ? 32'hDEAD_BEEF : tgt_val(cfg_req_devfn, cfg_req_reg);
            hs_count   <= hs_count + 1;
            last_fn    <= cfg_req_devfn;
            last_reg   <= cfg_req_reg;
            last_wdata <= cfg_req_wdata;
            last_write <= cfg_req_write;
        end
    end

    // Ready generator with a programmable stall, plus hold watch
    always @(negedge clk) begin
        if (cfg_req_valid) begin
            if (seen_cnt == 0) begin
                watch_reg   = cfg_req_reg;
                watch_wdata = cfg_req_wdata;
            end else if (watch_reg != cfg_req_reg || watch_wdata != cfg_req_wdata) begin
                hold_err = hold_err + 1;
            end
            cfg_req_ready = (seen_cnt == stall_cycles);
            seen_cnt = seen_cnt + 1;
        end else begin
            cfg_req_ready = 1'b0;
            seen_cnt = 0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic access(input logic port, input logic [1:0] off, input logic [1:0] sz,
                          input logic wr, input logic [31:0] wd,
                          output logic [31:0] rd, output int lat);
        @(negedge clk);
        host_valid = 1'b1; host_port = port; host_byte_off = off;
        host_size = sz; host_write = wr; host_wdata = wd;
        lat = 0;
        rd = '0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            lat++;
            if (lat == 1) host_valid = 1'b0;
            if (host_done) begin
                rd = host_rdata;
                break;
            end
        end
    endtask

    task automatic set_sel(input logic [31:0] v);
        logic [31:0] rd;
        int lat;
        access(1'b0, 2'b00, 2'b10, 1'b1, v, rd, lat);
    endtask

    task automatic t_reset;
        logic [31:0] rd;
        int lat;
        check(cfg_req_valid == 1'b0 && host_done == 1'b0, "R8 idle outputs",
              {30'd0, cfg_req_valid, host_done}, 32'd0);
        access(1'b0, 2'b00, 2'b10, 1'b0, '0, rd, lat);
        check(rd == 32'd0, "R8 latch after reset", rd, 32'd0);
    endtask

    task automatic t_addr_port;
        logic [31:0] rd;
        int lat;
        access(1'b0, 2'b00, 2'b10, 1'b1, 32'h8000_0810, rd, lat);
        check(lat == 1, "R1 write latency", lat, 1);
        access(1'b0, 2'b00, 2'b10, 1'b0, '0, rd, lat);
        check(rd == 32'h8000_0810 && lat == 1, "R1 latch readback", rd, 32'h8000_0810);
    endtask

    task automatic t_addr_narrow;
        logic [31:0] rd;
        int lat;
        access(1'b0, 2'b00, 2'b00, 1'b1, 32'h0000_0000, rd, lat);
        access(1'b0, 2'b01, 2'b01, 1'b1, 32'h0000_FFFF, rd, lat);
        access(1'b0, 2'b00, 2'b10, 1'b0, '0, rd, lat);
        check(rd == 32'h8000_0810, "R2 narrow write ignored", rd, 32'h8000_0810);
        access(1'b0, 2'b00, 2'b00, 1'b0, '0, rd, lat);
        check(rd == 32'h0000_00FF, "R2 byte read ones", rd, 32'h0000_00FF);
        access(1'b0, 2'b00, 2'b01, 1'b0, '0, rd, lat);
        check(rd == 32'h0000_FFFF, "R2 word read ones", rd, 32'h0000_FFFF);
    endtask

    task automatic t_disabled;
        logic [31:0] rd;
        int lat, hs0;
        set_sel(32'h0000_0810);
        access(1'b1, 2'b00, 2'b10, 1'b0, '0, rd, lat);
        check(rd == 32'hFFFF_FFFF && lat == 1, "R3 dword read disabled", rd, 32'hFFFF_FFFF);
        access(1'b1, 2'b01, 2'b00, 1'b0, '0, rd, lat);
        check(rd == 32'h0000_00FF, "R3 byte read disabled", rd, 32'h0000_00FF);
        hs0 = hs_count;
        access(1'b1, 2'b00, 2'b01, 1'b1, 32'h1234, rd, lat);
        check(hs_count == hs0 && lat == 1, "R3 write dropped", hs_count, hs0);
    endtask

    task automatic t_miss;
        logic [31:0] rd;
        int lat, hs0;
        set_sel(32'h8001_0810);
        access(1'b1, 2'b10, 2'b01, 1'b0, '0, rd, lat);
        check(rd == 32'h0000_FFFF, "R4 bus mismatch word", rd, 32'h0000_FFFF);
        set_sel(32'h8000_1810);
        access(1'b1, 2'b00, 2'b10, 1'b0, '0, rd, lat);
        check(rd == 32'hFFFF_FFFF, "R4 absent function", rd, 32'hFFFF_FFFF);
        hs0 = hs_count;
        access(1'b1, 2'b00, 2'b10, 1'b1, 32'h5555_AAAA, rd, lat);
        check(hs_count == hs0, "R4 absent write dropped", hs_count, hs0);
    endtask

    task automatic t_hit_reads;
        logic [31:0] rd, exp;
        int lat;
        stall_cycles = 0;
        set_sel(32'h8000_0813);
        access(1'b1, 2'b10, 2'b10, 1'b0, '0, rd, lat);
        exp = tgt_val(8'h08, 8'h10);
        check(rd == exp && lat == 3, "R5 dword aligned read", rd, exp);
        check(last_reg == 8'h10 && last_fn == 8'h08, "R5 dword offset", {last_fn, last_reg}, 32'h0810);
        set_sel(32'h8000_1020);
        access(1'b1, 2'b11, 2'b00, 1'b0, '0, rd, lat);
        exp = tgt_val(8'h10, 8'h23) & 32'hFF;
        check(rd == exp && last_reg == 8'h23, "R5 R6 byte read offset", rd, exp);
        set_sel(32'h8000_0012);
        access(1'b1, 2'b01, 2'b01, 1'b0, '0, rd, lat);
        exp = tgt_val(8'h00, 8'h13) & 32'hFFFF;
        check(rd == exp && last_reg == 8'h13, "R5 R6 word read offset", rd, exp);
    endtask

    task automatic t_hit_writes;
        logic [31:0] rd;
        int lat;
        set_sel(32'h8000_0840);
        access(1'b1, 2'b01, 2'b00, 1'b1, 32'hCAFE_BEEF, rd, lat);
        check(last_write && last_wdata == 32'hEF && last_reg == 8'h41, "R6 byte write", last_wdata, 32'hEF);
        access(1'b1, 2'b10, 2'b01, 1'b1, 32'h1234_5678, rd, lat);
        check(last_wdata == 32'h5678 && last_reg == 8'h42, "R6 word write", last_wdata, 32'h5678);
        access(1'b1, 2'b11, 2'b10, 1'b1, 32'h1234_5678, rd, lat);
        check(last_wdata == 32'h1234_5678 && last_reg == 8'h40, "R6 dword write", last_wdata, 32'h1234_5678);
    endtask

    task automatic t_stall;
        logic [31:0] rd, exp;
        int lat, hs0;
        stall_cycles = 3;
        hold_err = 0;
        hs0 = hs_count;
        set_sel(32'h8000_F804);
        access(1'b1, 2'b00, 2'b10, 1'b0, '0, rd, lat);
        exp = tgt_val(8'hF8, 8'h04);
        check(rd == exp && lat == 6, "R7 stalled read latency", lat, 6);
        check(hold_err == 0 && hs_count == hs0 + 1, "R7 request held", hold_err, 0);
    endtask

    task automatic t_busy_strobe;
        logic [31:0] rd, exp;
        int lat, hs0;
        stall_cycles = 4;
        hs0 = hs_count;
        @(negedge clk);
        host_valid = 1'b1; host_port = 1'b1; host_byte_off = 2'b00;
        host_size = 2'b10; host_write = 1'b0;
        lat = 0;
        rd = '0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            lat++;
            if (lat == 1) host_valid = 1'b0;
            if (lat == 2) begin
                host_valid = 1'b1; host_port = 1'b0; host_size = 2'b10;
                host_write = 1'b1; host_wdata = 32'h0000_0000;
            end
            if (lat == 3) host_valid = 1'b0;
            if (host_done) begin
                rd = host_rdata;
                break;
            end
        end
        exp = tgt_val(8'hF8, 8'h04);
        check(rd == exp && lat == 7, "R9 busy latency", lat, 7);
        check(hs_count == hs0 + 1, "R9 single request", hs_count, hs0 + 1);
        access(1'b0, 2'b00, 2'b10, 1'b0, '0, rd, lat);
        check(rd == 32'h8000_F804, "R9 latch untouched", rd, 32'h8000_F804);
        stall_cycles = 0;
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        dev_present[8'h00] = 1'b1;
        dev_present[8'h08] = 1'b1;
        dev_present[8'h10] = 1'b1;
        dev_present[8'hF8] = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_addr_port();
        t_addr_narrow();
        t_disabled();
        t_miss();
        t_hit_reads();
        t_hit_writes();
        t_stall();
        t_busy_strobe();
        repeat (3) @(negedge clk);
        report();
        $finish;
    end

endmodule